// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector load or store into a stream of byte addresses, one element per accepted cycle. A start pulse captures the addressing mode, the element width, a base address, a byte stride and the active element range. Elements from the start index up to, but not including, the vector length are then issued in ascending index order. Each request carries the address, the element index, the access size in bytes and a flag on the final element.

Three addressing modes share one datapath. In unit-stride mode the elements are packed back to back. In strided mode each element sits a programmable number of bytes after the previous one. In indexed mode each element's address is the base plus a byte offset taken from a separate offset stream. The memory port applies backpressure through a ready/valid handshake. In indexed mode the offset stream is consumed in step with that handshake. When the range is empty the block raises its done pulse without issuing anything.

Top module: `vaddr_seq`

## Requirements
- R1: Mode code 0 selects unit-stride addressing. Element i is at base + i * size, where size is the element size in bytes.
- R2: Mode code 1 selects strided addressing. Element i is at base + i * stride, where the stride is a two's-complement byte count. All address arithmetic wraps modulo 2^ADDR_W.
- R3: Mode code 2 selects indexed addressing. Element i is at base + offs, where offs is the offset word presented with it. One offset is consumed (offs_ready_o high together with offs_valid_i) exactly on each accepted request.
- R4: The first element issued has index vstart_i, and its address follows the mode's formula for that index.
- R5: Consecutive requests carry consecutive indices. req_last_o is high only on index vl-1, and exactly vl - vstart elements are issued.
- R6: If vstart_i >= vl_i at the start pulse (this includes vl_i = 0), the block issues no request and raises done_o in the next cycle.
- R7: While req_valid_o is high and req_ready_i is low, the request index and address stay unchanged.
- R8: The element width code sew_i (0, 1, 2, 3) is reported as req_size_o = 1, 2, 4, 8 bytes.
- R9: A start pulse that arrives while a sequence is running has no effect on that sequence.
- R10: done_o is a one-cycle pulse in the cycle after the final element is accepted. From that cycle on the block is idle.
- R11: After reset, busy_o, done_o, req_valid_o and offs_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| mode_i | input | 2 | Addressing mode: 0 unit, 1 strided, 2 indexed |
| sew_i | input | 2 | Element width code (0..3 for 8..64 bits) |
| base_i | input | ADDR_W | Scalar base byte address |
| stride_i | input | ADDR_W | Byte stride for strided mode |
| vl_i | input | VL_W | Vector length (end index, exclusive) |
| vstart_i | input | VL_W | First element index |
| offs_i | input | ADDR_W | Byte offset for the current indexed element |
| offs_valid_i | input | 1 | Offset word valid |
| offs_ready_o | output | 1 | Offset word consumed this cycle when valid |
| req_valid_o | output | 1 | Address request valid |
| req_ready_i | input | 1 | Memory port accepts the request |
| req_addr_o | output | ADDR_W | Element byte address |
| req_idx_o | output | VL_W | Element index |
| req_size_o | output | 4 | Access size in bytes |
| req_last_o | output | 1 | Final element of the sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench covers several corner cases and the failure each one exposes. A range that starts past element zero would expose a design that begins at index 0 or forgets to pre-offset the first address. A negative stride and a base near the top of the address space would expose wrong sign handling or wrong wrap-around. A stalled memory port would expose a design that advances the index or the running address on valid alone. Empty ranges, with vl zero or vstart at or beyond vl, would expose a design that emits a stray request or never reports done. A second start during a running sequence would expose a design that reloads its base or count.

// File: rtl/vaddr_pkg.sv
// Package: shared types for the vector address sequencer.
// Assumes: mode codes are fixed by the instruction decoder upstream.
package vaddr_pkg;
    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2
    } amode_e;
endpackage

// File: rtl/vaddr_size_dec.sv
// Module: vaddr_size_dec
// Converts an element width code into a byte count.
// Assumes: code 0..3 means 8, 16, 32, 64-bit elements; purely combinational.
module vaddr_size_dec #(
    parameter int SZ_W = 4
) (
    input  logic [1:0]      sew_i,
    output logic [SZ_W-1:0] bytes_o
);
    // decode: one-hot byte count from the width code
    always_comb begin
        bytes_o = '0;
        bytes_o[sew_i] = 1'b1;
    end
endmodule

// File: rtl/vaddr_ctrl.sv
// Module: vaddr_ctrl
// Element counter and sequence control: accepts a start when idle,
// walks the index from vstart to vl-1 on each handshake, pulses done.
// Assumes: fire_i is only high while busy_o is high.
module vaddr_ctrl #(
    parameter int VL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [VL_W-1:0] vl_i,
    input  logic [VL_W-1:0] vstart_i,
    input  logic            fire_i,
    output logic            load_o,
    output logic            busy_o,
    output logic [VL_W-1:0] idx_o,
    output logic            last_o,
    output logic            done_o
);
    logic [VL_W-1:0] vl_q;
    logic            accept;
    logic            empty;

    // start decode: accepted only when idle; an empty range skips straight to done
    always_comb begin
        accept = start_i && !busy_o;
        empty  = (vstart_i >= vl_i);
        load_o = accept && !empty;
        last_o = busy_o && (idx_o == vl_q - 1'b1);
    end

    // sequence state: busy flag, current index, captured length, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            idx_o  <= '0;
            vl_q   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                if (empty) begin
                    done_o <= 1'b1;
                end else begin
                    busy_o <= 1'b1;
                    idx_o  <= vstart_i;
                    vl_q   <= vl_i;
                end
            end else if (busy_o && fire_i) begin
                if (last_o) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    idx_o <= idx_o + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vaddr_gen.sv
// Module: vaddr_gen
// Address datapath: keeps a running address for unit and strided modes,
// adds the streamed offset to the base for indexed mode.
// Assumes: ADDR_W > VL_W; load_i and fire_i are never high together.
module vaddr_gen
    import vaddr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 8,
    parameter int SZ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              fire_i,
    input  amode_e            mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [VL_W-1:0]   vstart_i,
    input  logic [SZ_W-1:0]   bytes_i,
    input  logic [ADDR_W-1:0] offs_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SZ_W-1:0]   size_o,
    output logic              indexed_o
);
    localparam int PAD_VS = ADDR_W - VL_W;
    localparam int PAD_SZ = ADDR_W - SZ_W;

    amode_e            mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] step_q;
    logic [ADDR_W-1:0] run_q;
    logic [ADDR_W-1:0] step_d;
    logic [ADDR_W-1:0] first_d;

    // step select and first-element address (base + vstart * step)
    always_comb begin
        step_d  = (mode_i == AM_UNIT) ? {{PAD_SZ{1'b0}}, bytes_i} : stride_i;
        first_d = base_i + ({{PAD_VS{1'b0}}, vstart_i} * step_d);
    end

    // captured configuration and running address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= AM_UNIT;
            base_q <= '0;
            step_q <= '0;
            run_q  <= '0;
            size_o <= '0;
        end else if (load_i) begin
            mode_q <= mode_i;
            base_q <= base_i;
            step_q <= step_d;
            run_q  <= first_d;
            size_o <= bytes_i;
        end else if (fire_i) begin
            run_q  <= run_q + step_q;
        end
    end

    // output address: indexed uses the live offset, the others the running sum
    always_comb begin
        indexed_o = (mode_q == AM_INDEX);
        addr_o    = indexed_o ? (base_q + offs_i) : run_q;
    end
endmodule

// File: rtl/vaddr_seq.sv
// Module: vaddr_seq (top)
// Vector memory address sequencer: one element address per handshake,
// unit-stride, strided or indexed, from element vstart to vl-1.
// Assumes: the offset source holds its word while offs_ready_o is low.
module vaddr_seq
    import vaddr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        sew_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [VL_W-1:0]   vstart_i,
    input  logic [ADDR_W-1:0] offs_i,
    input  logic              offs_valid_i,
    output logic              offs_ready_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [VL_W-1:0]   req_idx_o,
    output logic [3:0]        req_size_o,
    output logic              req_last_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int SZ_W = 4;

    logic [SZ_W-1:0] bytes;
    logic            load;
    logic            fire;
    logic            indexed;

    vaddr_size_dec #(.SZ_W(SZ_W)) size_i (
        .sew_i   (sew_i),
        .bytes_o (bytes)
    );

    vaddr_ctrl #(.VL_W(VL_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .vl_i     (vl_i),
        .vstart_i (vstart_i),
        .fire_i   (fire),
        .load_o   (load),
        .busy_o   (busy_o),
        .idx_o    (req_idx_o),
        .last_o   (req_last_o),
        .done_o   (done_o)
    );

    vaddr_gen #(.ADDR_W(ADDR_W), .VL_W(VL_W), .SZ_W(SZ_W)) gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .fire_i    (fire),
        .mode_i    (amode_e'(mode_i)),
        .base_i    (base_i),
        .stride_i  (stride_i),
        .vstart_i  (vstart_i),
        .bytes_i   (bytes),
        .offs_i    (offs_i),
        .addr_o    (req_addr_o),
        .size_o    (req_size_o),
        .indexed_o (indexed)
    );

    // handshake: indexed requests also wait for an offset word
    always_comb begin
        req_valid_o  = busy_o && (!indexed || offs_valid_i);
        fire         = req_valid_o && req_ready_i;
        offs_ready_o = busy_o && indexed && req_ready_i;
    end
endmodule

// File: rtl/vaddr_seq_chk.sv
// Module: vaddr_seq_chk
// Protocol checker for vaddr_seq, attached to every instance by bind.
// Assumes: the offset source keeps offs_valid_i high once presented.
module vaddr_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [VL_W-1:0]   req_idx_o,
    input logic [3:0]        req_size_o,
    input logic              req_last_o,
    input logic              busy_o,
    input logic              done_o
);
    // R7: a stalled request keeps its index
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_idx_o));

    // R5: an accepted non-final element is followed by the next index
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i && !req_last_o |=>
            busy_o && (req_idx_o == $past(req_idx_o) + 1'b1));

    // R10: accepting the final element ends the sequence with done
    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i && req_last_o |=> done_o && !busy_o);

    // R10: done is never raised while a sequence runs
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: access size is a single power of two
    p_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> ($countones(req_size_o) == 1));

    // R6: no request outside a running sequence
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !req_valid_o);
endmodule

bind vaddr_seq vaddr_seq_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .req_idx_o   (req_idx_o),
    .req_size_o  (req_size_o),
    .req_last_o  (req_last_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/vaddr_seq_tb_top.sv
// Bench for vaddr_seq: a vector table walked by one loop, then directed
// tests for reset, restart-while-busy and empty ranges.
module vaddr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int VL_W   = 8;
    localparam int NVEC   = 11;
    // vector layout: mode[84:83] sew[82:81] base[80:49] stride[48:17] vl[16:9] vstart[8:1] stall[0]
    localparam logic [84:0] TAB [NVEC] = '{
        {2'd0, 2'd0, 32'h0000_1000, 32'h0,         8'd5, 8'd0, 1'b0},
        {2'd0, 2'd2, 32'h0000_2000, 32'h0,         8'd4, 8'd1, 1'b1},
        {2'd0, 2'd3, 32'hFFFF_FFF0, 32'h0,         8'd3, 8'd0, 1'b0},
        {2'd1, 2'd1, 32'h0000_0100, 32'd12,        8'd4, 8'd0, 1'b1},
        {2'd1, 2'd2, 32'h0000_0800, 32'hFFFF_FFF8, 8'd5, 8'd2, 1'b0},
        {2'd2, 2'd0, 32'h0000_4000, 32'h0,         8'd4, 8'd0, 1'b1},
        {2'd2, 2'd3, 32'h0000_0010, 32'h0,         8'd6, 8'd3, 1'b0},
        {2'd0, 2'd0, 32'h0000_5000, 32'h0,         8'd0, 8'd0, 1'b0},
        {2'd1, 2'd1, 32'h0000_6000, 32'd4,         8'd3, 8'd3, 1'b0},
        {2'd2, 2'd2, 32'h0000_7000, 32'h0,         8'd3, 8'd5, 1'b0},
        {2'd1, 2'd0, 32'h0000_8000, 32'h0,         8'd3, 8'd0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [1:0]        mode_i = '0;
    logic [1:0]        sew_i = '0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [ADDR_W-1:0] stride_i = '0;
    logic [VL_W-1:0]   vl_i = '0;
    logic [VL_W-1:0]   vstart_i = '0;
    logic [ADDR_W-1:0] offs_i = '0;
    logic              offs_valid_i = 1'b1;
    logic              offs_ready_o;
    logic              req_valid_o;
    logic              req_ready_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_o;
    logic [VL_W-1:0]   req_idx_o;
    logic [3:0]        req_size_o;
    logic              req_last_o;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vaddr_seq #(.ADDR_W(ADDR_W), .VL_W(VL_W)) dut_i (.*);

    // offset word for element i (descending, so indexed order is visible)
    function automatic logic [ADDR_W-1:0] offs_of(input int i);
        return 32'h200 - 32'(i * 24);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // run one sequence; poke=1 fires a second start during element 1 (R9)
    task automatic run_case(input logic [84:0] v, input bit poke);
        logic [1:0]  md  = v[84:83];
        logic [1:0]  sw  = v[82:81];
        logic [31:0] bs  = v[80:49];
        logic [31:0] st  = v[48:17];
        int          vl  = int'(v[16:9]);
        int          vs  = int'(v[8:1]);
        bit          stall = v[0];
        int          n   = (vs >= vl) ? 0 : vl - vs;
        int          k   = 0;
        int          cyc = 0;
        string       tag = (md == 2'd0) ? "R1" : (md == 2'd1) ? "R2" : "R3";
        @(negedge clk);
        start_i = 1'b1; mode_i = md; sew_i = sw; base_i = bs; stride_i = st;
        vl_i = VL_W'(vl); vstart_i = VL_W'(vs); req_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        if (n == 0) begin
            #1;
            // R6: empty range: done next cycle, no request
            check(done_o && !req_valid_o && !busy_o, "R6",
                  {61'd0, done_o, req_valid_o, busy_o}, 64'h4);
            @(negedge clk); #1;
            check(!done_o && !req_valid_o, "R10", {62'd0, done_o, req_valid_o}, 64'h0);
            return;
        end
        while (k < n && cyc < 200) begin
            logic [31:0] ea;
            logic [45:0] act, exp;
            int i = vs + k;
            if (cyc != 0) @(negedge clk);
            req_ready_i = stall ? cyc[0] : 1'b1;
            offs_i = offs_of(i);
            if (poke && k == 1 && !stall) begin
                start_i = 1'b1; base_i = 32'h9000_0000; vl_i = 8'd1; vstart_i = 8'd0;
            end else begin
                start_i = 1'b0;
            end
            #1;
            case (md)
                2'd0:    ea = bs + 32'(i << sw);          // R1, R4
                2'd1:    ea = bs + 32'(i) * st;           // R2, R4
                default: ea = bs + offs_of(i);            // R3
            endcase
            // R5 index/last, R7 held while stalled, R8 size
            exp = {1'b1, (k == n-1), 4'(1 << sw), VL_W'(i), ea};
            act = {req_valid_o, req_last_o, req_size_o, req_idx_o, req_addr_o};
            check(act == exp && (md != 2'd2 || offs_ready_o == req_ready_i),
                  poke ? "R9" : tag, 64'(act), 64'(exp));
            if (req_ready_i && req_valid_o) k++;
            cyc++;
        end
        start_i = 1'b0;
        @(negedge clk); req_ready_i = 1'b0; #1;
        // R10: done pulse right after the final element
        check(done_o && !busy_o && !req_valid_o, "R10",
              {61'd0, done_o, busy_o, req_valid_o}, 64'h4);
        @(negedge clk); #1;
        check(!done_o, "R10", {63'd0, done_o}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        check(!busy_o && !done_o && !req_valid_o && !offs_ready_o, "R11",
              {60'd0, busy_o, done_o, req_valid_o, offs_ready_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!busy_o && !req_valid_o, "R11", {62'd0, busy_o, req_valid_o}, 64'h0);
        for (int t = 0; t < NVEC; t++) run_case(TAB[t], 1'b0);
        // R9: restart during a running unit-stride sequence is ignored
        run_case({2'd0, 2'd1, 32'h0000_3000, 32'h0, 8'd4, 8'd0, 1'b0}, 1'b1);
        // R3 with the offset stream starved for one cycle: no request issued
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'd2; sew_i = 2'd0; base_i = 32'h100; vl_i = 8'd1;
        vstart_i = 8'd0; offs_valid_i = 1'b0; req_ready_i = 1'b1;
        @(negedge clk); start_i = 1'b0; #1;
        check(!req_valid_o && busy_o && !offs_ready_o == 1'b0, "R3",
              {62'd0, req_valid_o, busy_o}, 64'h1);
        offs_i = 32'h20; offs_valid_i = 1'b1; #1;
        check(req_valid_o && req_addr_o == 32'h120 && req_last_o, "R3",
              {31'd0, req_valid_o, req_addr_o}, {31'd0, 1'b1, 32'h120});
        @(negedge clk); #1;
        check(done_o && !busy_o, "R10", {62'd0, done_o, busy_o}, 64'h2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule